// File: doc/BRIEF.md
# EEPROM Configuration Loader with Checksum

After reset is released, this block fetches the device setup from an external serial EEPROM, one byte at a time, through a simple request/acknowledge byte-read port. The bit-level serial master sits outside the block. The loader copies the fourteen setup bytes into configuration registers and writes the breakpoint table bytes into a local table RAM. It adds every byte it accepts into an 8-bit running sum. When loading ends, it compares that sum with the checksum byte stored in the EEPROM.

The number of bytes read depends on the EEPROM contents. Table blocks are six bytes long, and the first byte of each block is its breakpoint. The load ends with the first block, from the second block onward, whose breakpoint is 255. A good load raises a done flag, and only then do the configuration registers show the loaded values instead of their defaults. Any of the following latches an error that drives an active-low error pin until the next reset:
- a read failure,
- a checksum mismatch,
- a table that has no end marker.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: In reset and right after it, `load_done` is 0, `load_err_n` is 1, `cfg_bus` holds the default value (0x00) in every byte, `tbl_blocks` is 0, and the first request addresses EEPROM byte 0x01.
- R2: `ee_req` stays high with `ee_addr` unchanged until `ee_ack`. After each accepted byte, the address advances by one. Byte 0x00 is never read, so reads run 0x01, 0x02, … in order.
- R3: After a good load, byte k of `cfg_bus` (bits 8k+7:8k, k = 0..13) equals EEPROM byte 0x01+k. Byte 0x0F is taken as the stored checksum.
- R4: After a good load, table index i read through `tbl_addr`/`tbl_data` (combinational read) equals EEPROM byte 0x10+i, for every byte of the active blocks.
- R5: Block n occupies EEPROM bytes 0x10+6n to 0x15+6n, and its first byte is the breakpoint. The load ends after the block whose breakpoint is 255. `tbl_blocks` then gives the number of blocks read, and no further requests are issued.
- R6: A breakpoint of 255 in block 0 does not end the load, so at least two blocks are always read.
- R7: A load is good when the 8-bit sum of bytes 0x01–0x0E plus all active table bytes equals byte 0x0F. `load_done` then rises at the clock edge that accepts the final byte.
- R8: On a checksum mismatch, `load_err_n` goes low, `load_done` stays low, and `cfg_bus` keeps its defaults.
- R9: If 16 blocks are read with no 255 breakpoint, the load stops with the error set. An EEPROM that reads as all zeros therefore ends in error, even though its sum matches.
- R10: An acknowledged byte with `ee_fail` high sets the error at that edge. The byte is not used, and no further request follows.
- R11: Done and error both persist until reset, and each reset starts a fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ee_req | output | 1 | Byte read request |
| ee_addr | output | 8 | EEPROM byte address of the request |
| ee_ack | input | 1 | One-cycle response strobe |
| ee_data | input | 8 | Byte returned with `ee_ack` |
| ee_fail | input | 1 | The read answered by `ee_ack` failed |
| cfg_bus | output | 112 | Fourteen configuration bytes, defaults until done |
| tbl_addr | input | 7 | Table read index |
| tbl_data | output | 8 | Table byte at `tbl_addr`, 0 until done |
| tbl_blocks | output | 5 | Active block count after a good load, else 0 |
| load_done | output | 1 | Load finished with a good checksum |
| load_err_n | output | 1 | Sticky load error, active low |

## Verification
The responder drives `ee_ack` on a falling edge, and the loader takes the byte at the next rising edge. The new address and the final result are therefore visible at the falling edge one cycle after the acknowledge is driven. The bench records the rising-edge count at each acknowledge and requires `load_done` to be first seen exactly one count after the last one. All sampling and driving happens 2 ns after a falling edge, so no value is read at the edge where it changes. Table contents are read combinationally, 1 ns after `tbl_addr` is set. Request counts are checked again eight cycles after completion to confirm the bus stays quiet.

// File: rtl/cfgld_pkg.sv
// Shared definitions for the EEPROM configuration loader.
// Assumes an 8-bit EEPROM byte address space.
package cfgld_pkg;
    typedef enum logic [2:0] {
        ST_CFG  = 3'd0,   // fetching setup bytes
        ST_SUM  = 3'd1,   // fetching the stored checksum
        ST_TBL  = 3'd2,   // fetching table blocks
        ST_DONE = 3'd3,   // good load, idle
        ST_FAIL = 3'd4    // sticky error, idle
    } ld_state_t;

    localparam logic [7:0] END_MARK = 8'hFF;
endpackage

// File: rtl/cfgld_seq.sv
// Load sequencer: walks the EEPROM addresses, accumulates the checksum,
// detects the table end marker and decides between done and error.
// Assumes ee_ack is a one-cycle strobe answering the current request.
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int NUM_CFG   = 14,
    parameter int BLK_BYTES = 6,
    parameter int MIN_BLK   = 2,
    parameter int MAX_BLK   = 16,
    localparam int CFG_IW    = $clog2(NUM_CFG),
    localparam int TBL_DEPTH = MAX_BLK * BLK_BYTES,
    localparam int TBL_AW    = $clog2(TBL_DEPTH + 1),
    localparam int BLK_W     = $clog2(MAX_BLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_req,
    output logic [7:0]        ee_addr,
    input  logic              ee_ack,
    input  logic [7:0]        ee_data,
    input  logic              ee_fail,
    output logic              wr_cfg,
    output logic              wr_tbl,
    output logic [CFG_IW-1:0] wr_cfg_idx,
    output logic [TBL_AW-1:0] wr_tbl_idx,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              failed,
    output logic [BLK_W-1:0]  blocks
);
    localparam int BYTE_W = $clog2(BLK_BYTES);
    localparam logic [7:0]        LAST_CFG_A = 8'(NUM_CFG);
    localparam logic [BYTE_W-1:0] BYT_LAST   = BYTE_W'(BLK_BYTES - 1);
    localparam logic [BLK_W-1:0]  BLK_END_OK = BLK_W'(MIN_BLK - 1);
    localparam logic [BLK_W-1:0]  BLK_LAST   = BLK_W'(MAX_BLK - 1);

    ld_state_t         state;
    logic [7:0]        addr;
    logic [BLK_W-1:0]  blk;
    logic [BYTE_W-1:0] byt;
    logic [7:0]        sum;
    logic [7:0]        ref_sum;
    logic [7:0]        sum_next;
    logic              last_blk;
    logic [TBL_AW-1:0] tbl_idx;
    logic [BLK_W-1:0]  blocks_q;
    logic              accept;

    // Request and write-strobe decode from the current state.
    always_comb begin
        ee_req     = (state == ST_CFG) || (state == ST_SUM) || (state == ST_TBL);
        ee_addr    = addr;
        accept     = ee_req && ee_ack;
        wr_cfg     = accept && !ee_fail && (state == ST_CFG);
        wr_tbl     = accept && !ee_fail && (state == ST_TBL);
        wr_cfg_idx = CFG_IW'(addr - 8'd1);
        wr_tbl_idx = tbl_idx;
        wr_data    = ee_data;
        sum_next   = sum + ee_data;
        done       = (state == ST_DONE);
        failed     = (state == ST_FAIL);
        blocks     = blocks_q;
    end

    // Sequencer state, address walk, block tracking and checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CFG;
            addr     <= 8'd1;
            blk      <= '0;
            byt      <= '0;
            sum      <= '0;
            ref_sum  <= '0;
            last_blk <= 1'b0;
            tbl_idx  <= '0;
            blocks_q <= '0;
        end else if (accept) begin
            if (ee_fail) begin
                state <= ST_FAIL;
            end else begin
                case (state)
                    ST_CFG: begin
                        sum  <= sum_next;
                        addr <= addr + 8'd1;
                        if (addr == LAST_CFG_A) state <= ST_SUM;
                    end
                    ST_SUM: begin
                        ref_sum <= ee_data;
                        addr    <= addr + 8'd1;
                        state   <= ST_TBL;
                    end
                    ST_TBL: begin
                        sum     <= sum_next;
                        addr    <= addr + 8'd1;
                        tbl_idx <= tbl_idx + 1'b1;
                        if (byt == '0) begin
                            last_blk <= (ee_data == END_MARK) && (blk >= BLK_END_OK);
                            byt      <= byt + 1'b1;
                        end else if (byt == BYT_LAST) begin
                            byt <= '0;
                            blk <= blk + 1'b1;
                            if (last_blk) begin
                                state    <= (sum_next == ref_sum) ? ST_DONE : ST_FAIL;
                                blocks_q <= (sum_next == ref_sum) ? blk + 1'b1 : '0;
                            end else if (blk == BLK_LAST) begin
                                state <= ST_FAIL;
                            end
                        end else begin
                            byt <= byt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgld_store.sv
// Storage for the loaded setup: one register per configuration byte and
// the breakpoint table RAM. Configuration outputs show the default value
// and table reads return zero until the load is marked done.
module cfgld_store #(
    parameter int         NUM_CFG     = 14,
    parameter int         TBL_DEPTH   = 96,
    parameter logic [7:0] CFG_DEFAULT = 8'h00,
    localparam int CFG_IW = $clog2(NUM_CFG),
    localparam int TBL_AW = $clog2(TBL_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_cfg,
    input  logic                 wr_tbl,
    input  logic [CFG_IW-1:0]    wr_cfg_idx,
    input  logic [TBL_AW-1:0]    wr_tbl_idx,
    input  logic [7:0]           wr_data,
    input  logic                 done,
    output logic [NUM_CFG*8-1:0] cfg_bus,
    input  logic [TBL_AW-1:0]    tbl_addr,
    output logic [7:0]           tbl_data
);
    localparam logic [TBL_AW:0] DEPTH_W = (TBL_AW + 1)'(TBL_DEPTH);

    logic [7:0] tbl_mem [TBL_DEPTH];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        logic [7:0] q;
        // Capture configuration byte g when the sequencer writes it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         q <= CFG_DEFAULT;
            else if (wr_cfg && (wr_cfg_idx == CFG_IW'(g)))      q <= wr_data;
        end
        assign cfg_bus[g*8 +: 8] = done ? q : CFG_DEFAULT;
    end

    // Table RAM: clear on reset, fill in load order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_DEPTH; i++) tbl_mem[i] <= 8'h00;
        end else if (wr_tbl && ({1'b0, wr_tbl_idx} < DEPTH_W)) begin
            tbl_mem[wr_tbl_idx] <= wr_data;
        end
    end

    // Combinational table read, gated until a good load.
    always_comb begin
        if (done && ({1'b0, tbl_addr} < DEPTH_W)) tbl_data = tbl_mem[tbl_addr];
        else                                      tbl_data = 8'h00;
    end
endmodule

// File: rtl/eeprom_cfg_loader.sv
// Top of the EEPROM configuration loader: joins the sequencer and the
// storage and exposes the active-low error pin. Assumes the byte-read
// responder holds no state between requests.
module eeprom_cfg_loader #(
    parameter int         NUM_CFG     = 14,
    parameter int         BLK_BYTES   = 6,
    parameter int         MIN_BLK     = 2,
    parameter int         MAX_BLK     = 16,
    parameter logic [7:0] CFG_DEFAULT = 8'h00,
    localparam int CFG_IW    = $clog2(NUM_CFG),
    localparam int TBL_DEPTH = MAX_BLK * BLK_BYTES,
    localparam int TBL_AW    = $clog2(TBL_DEPTH + 1),
    localparam int BLK_W     = $clog2(MAX_BLK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 ee_req,
    output logic [7:0]           ee_addr,
    input  logic                 ee_ack,
    input  logic [7:0]           ee_data,
    input  logic                 ee_fail,
    output logic [NUM_CFG*8-1:0] cfg_bus,
    input  logic [TBL_AW-1:0]    tbl_addr,
    output logic [7:0]           tbl_data,
    output logic [BLK_W-1:0]     tbl_blocks,
    output logic                 load_done,
    output logic                 load_err_n
);
    logic              wr_cfg;
    logic              wr_tbl;
    logic [CFG_IW-1:0] wr_cfg_idx;
    logic [TBL_AW-1:0] wr_tbl_idx;
    logic [7:0]        wr_data;
    logic              done;
    logic              failed;

    cfgld_seq #(
        .NUM_CFG(NUM_CFG), .BLK_BYTES(BLK_BYTES),
        .MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack),
        .ee_data(ee_data), .ee_fail(ee_fail),
        .wr_cfg(wr_cfg), .wr_tbl(wr_tbl), .wr_cfg_idx(wr_cfg_idx),
        .wr_tbl_idx(wr_tbl_idx), .wr_data(wr_data),
        .done(done), .failed(failed), .blocks(tbl_blocks)
    );

    cfgld_store #(
        .NUM_CFG(NUM_CFG), .TBL_DEPTH(TBL_DEPTH), .CFG_DEFAULT(CFG_DEFAULT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg(wr_cfg), .wr_tbl(wr_tbl), .wr_cfg_idx(wr_cfg_idx),
        .wr_tbl_idx(wr_tbl_idx), .wr_data(wr_data), .done(done),
        .cfg_bus(cfg_bus), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
    );

    assign load_done  = done;
    assign load_err_n = !failed;
endmodule

// File: rtl/cfgld_chk.sv
// Protocol and outcome checks for the loader, bound to its top.
module cfgld_chk #(
    parameter int         NUM_CFG     = 14,
    parameter int         MIN_BLK     = 2,
    parameter int         MAX_BLK     = 16,
    parameter logic [7:0] CFG_DEFAULT = 8'h00,
    localparam int BLK_W = $clog2(MAX_BLK + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ee_req,
    input logic [7:0]           ee_addr,
    input logic                 ee_ack,
    input logic                 ee_fail,
    input logic [NUM_CFG*8-1:0] cfg_bus,
    input logic [BLK_W-1:0]     tbl_blocks,
    input logic                 load_done,
    input logic                 load_err_n
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr))); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_ack && !ee_fail) |=> (!ee_req || ee_addr == $past(ee_addr) + 8'd1)); // R2
    AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_ack && ee_fail) |=> (!load_err_n && !ee_req)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !load_err_n |=> !load_err_n); // R11
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && !load_err_n)); // R8
    AST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (cfg_bus == {NUM_CFG{CFG_DEFAULT}} && tbl_blocks == '0)); // R8
    AST_BLOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (tbl_blocks >= BLK_W'(MIN_BLK) && tbl_blocks <= BLK_W'(MAX_BLK))); // R5
    AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done || !load_err_n) |-> !ee_req); // R5
endmodule

bind eeprom_cfg_loader cfgld_chk #(
    .NUM_CFG(NUM_CFG), .MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK), .CFG_DEFAULT(CFG_DEFAULT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_addr(ee_addr),
    .ee_ack(ee_ack), .ee_fail(ee_fail), .cfg_bus(cfg_bus),
    .tbl_blocks(tbl_blocks), .load_done(load_done), .load_err_n(load_err_n)
);

// File: tb/tb_eeprom_cfg_loader.sv
// Bench: EEPROM responder model with random latency, random images plus
// directed corner cases, expected values from bench functions.
module tb_eeprom_cfg_loader;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ee_req;
    logic [7:0]   ee_addr;
    logic         ee_ack = 1'b0;
    logic [7:0]   ee_data = 8'h00;
    logic         ee_fail = 1'b0;
    logic [111:0] cfg_bus;
    logic [6:0]   tbl_addr = '0;
    logic [7:0]   tbl_data;
    logic [4:0]   tbl_blocks;
    logic         load_done;
    logic         load_err_n;

    eeprom_cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_addr(ee_addr),
        .ee_ack(ee_ack), .ee_data(ee_data), .ee_fail(ee_fail),
        .cfg_bus(cfg_bus), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .tbl_blocks(tbl_blocks), .load_done(load_done), .load_err_n(load_err_n)
    );

    always #10 clk = ~clk;

    logic [7:0] mem [256];
    int tests = 0, fails = 0;
    int cyc = 0, nreads = 0, seq_bad = 0, exp_addr = 1, wait_cnt = 0;
    int last_ack_cyc = 0, fail_addr = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial forever @(posedge clk) cyc++;

    // Responder: answers the current request after 0..2 idle cycles.
    initial forever begin
        @(negedge clk);
        if (ee_ack) begin
            ee_ack = 1'b0; ee_fail = 1'b0;
        end else if (rst_n && ee_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                ee_ack  = 1'b1;
                ee_data = mem[ee_addr];
                ee_fail = (int'(ee_addr) == fail_addr);
                if (int'(ee_addr) != exp_addr) seq_bad++;
                exp_addr++;
                nreads++;
                last_ack_cyc = cyc;
                wait_cnt = int'($urandom % 3);
            end
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    function automatic logic [7:0] image_sum(input int nblk);
        logic [7:0] s = 8'h00;
        for (int a = 1; a <= 14; a++) s += mem[a];
        for (int a = 16; a < 16 + 6 * nblk; a++) s += mem[a];
        return s;
    endfunction

    task automatic build(input int nblk, input bit b0_end, input bit bad_sum, input bit no_mark);
        for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
        for (int k = 0; k < 16; k++) mem[16 + 6 * k] = 8'($urandom % 255);
        if (!no_mark) mem[16 + 6 * (nblk - 1)] = 8'hFF;
        if (b0_end) mem[16] = 8'hFF;
        mem[15] = image_sum(no_mark ? 16 : nblk) + (bad_sum ? 8'd1 : 8'd0);
    endtask

    task automatic run_load(input bit exp_ok, input int exp_reads, input int exp_blk, input string req);
        int n = 0;
        int n0;
        int bad = 0;
        int done_cyc;
        rst_n = 1'b0;
        step(); step();
        nreads = 0; seq_bad = 0; exp_addr = 1; wait_cnt = 0;
        chk(load_done == 1'b0 && load_err_n == 1'b1, "R1 flags in reset", int'(load_done), 0);
        chk(cfg_bus == '0 && tbl_blocks == '0, "R1 defaults in reset", int'(tbl_blocks), 0);
        chk(ee_addr == 8'h01, "R1 first address", int'(ee_addr), 1);
        rst_n = 1'b1;
        while (!load_done && load_err_n && n < 3000) begin step(); n++; end
        done_cyc = cyc;
        chk(n < 3000, {req, " load finished"}, n, 0);
        chk(load_done == exp_ok && load_err_n == exp_ok, {req, " outcome"}, int'(load_done), int'(exp_ok));
        chk(nreads == exp_reads, {req, " R5 read count"}, nreads, exp_reads);
        chk(seq_bad == 0, "R2 address order", seq_bad, 0);
        if (exp_ok) begin
            chk(done_cyc == last_ack_cyc + 1, "R7 done timing", done_cyc, last_ack_cyc + 1);
            chk(int'(tbl_blocks) == exp_blk, "R5 block count", int'(tbl_blocks), exp_blk);
            for (int k = 0; k < 14; k++) if (cfg_bus[k*8 +: 8] != mem[k + 1]) bad++;
            chk(bad == 0, "R3 config bytes", bad, 0);
            bad = 0;
            for (int i = 0; i < 6 * exp_blk; i++) begin
                tbl_addr = 7'(i); #1;
                if (tbl_data != mem[16 + i]) bad++;
            end
            chk(bad == 0, "R4 table bytes", bad, 0);
        end else begin
            chk(cfg_bus == '0 && tbl_blocks == '0, "R8 defaults kept on error", int'(tbl_blocks), 0);
        end
        n0 = nreads;
        repeat (8) step();
        chk(nreads == n0 && load_done == exp_ok && load_err_n == exp_ok,
            "R11 sticky and quiet", nreads, n0);
    endtask

    initial begin
        int nb;
        void'($urandom(32'd1234));
        build(2, 1'b1, 1'b0, 1'b0);                  // R6: block 0 breakpoint 255
        run_load(1'b1, 15 + 12, 2, "R6");
        for (int t = 0; t < 6; t++) begin            // R7 random good loads
            nb = 2 + int'($urandom % 15);
            build(nb, 1'b0, 1'b0, 1'b0);
            run_load(1'b1, 15 + 6 * nb, nb, "R7");
        end
        build(16, 1'b0, 1'b0, 1'b0);                 // R5 longest table
        run_load(1'b1, 111, 16, "R5");
        build(5, 1'b0, 1'b1, 1'b0);                  // R8 bad checksum
        run_load(1'b0, 45, 0, "R8");
        build(16, 1'b0, 1'b0, 1'b1);                 // R9 missing end marker
        run_load(1'b0, 111, 0, "R9");
        for (int a = 0; a < 256; a++) mem[a] = 8'h00; // R9 all-zero bus
        run_load(1'b0, 111, 0, "R9 zero");
        build(6, 1'b0, 1'b0, 1'b0);                  // R10 failure in table
        fail_addr = 16 + int'($urandom % 30);
        run_load(1'b0, fail_addr, 0, "R10");
        fail_addr = 3;                               // R10 failure in setup
        run_load(1'b0, 3, 0, "R10 cfg");
        fail_addr = -1;
        build(3, 1'b0, 1'b0, 1'b0);                  // R11 recovery after error
        run_load(1'b1, 33, 3, "R11");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule